// File: doc/BRIEF.md
# Serial Device Steering Decoder

This block sits between a host's 3-wire serial port (an active-low load strobe, a data line and a clock) and several serial devices that share one data line and one clock line. Each device has a load enable of its own. The block captures the first bits of every host frame. It decodes from them which device the frame is meant for, and then opens only that device's load enable. The whole frame goes out on the shared lines, from the first bit to the last.

The host inputs are brought into the system clock domain through two-flop synchronizers. A host bit is taken on each rising edge of the host clock. Every taken bit goes into a small bit queue. Once the target is known, a local serializer replays the queued bits to the device on its own clock. That clock is low for `HALF_CYCLES` system cycles and then high for `HALF_CYCLES` system cycles. The frame's leading bits, which had to be held back for the decision, therefore reach the device in full. Frames for the block's own register space only raise a flag. Malformed frames are kept away from every device and set a sticky error flag.

Frame layout as seen by the block:

- The select field comes first, most significant bit first.
- The direction bit follows it.
- The rest is target-specific and is forwarded untouched: an address sent least significant bit first, a test bit for the converters, then data sent least significant bit first.

Top module: `serial_steer_top`

## Requirements
- R1: A select value of 3'b001 drives `conv1_load_n` low, 3'b010 drives `conv2_load_n` low, and 3'b011 drives `tgen_load_n` low. The chosen enable stays low for the rest of the frame.
- R2: The select field is the first three bits taken on host clock rising edges while `host_load_n` is low. The first of those bits is the most significant bit of the select value.
- R3: Every bit of a routed frame is reproduced on `fwd_sdata`, in the order it arrived, and is valid at a rising edge of `fwd_sclk`. This includes the three select bits and the direction bit. `fwd_sdata` does not change while `fwd_sclk` is high.
- R4: No load enable opens, and no `fwd_sclk` pulse occurs, before the fourth bit (the direction bit) of a frame has been taken. At most one load enable is low at any time, and it does not change while `fwd_sclk` is high.
- R5: A select value of 3'b000 raises `local_frame` from the decision until the end of the frame. No load enable opens and `fwd_sclk` stays low during such a frame.
- R6: A select value from 3'b100 to 3'b111 keeps all load enables high and `fwd_sclk` low for the rest of the frame, and sets `frame_err`.
- R7: A direction bit of 1 (a read request) has the same effect as an unused select code: no load enable opens, nothing is forwarded, and `frame_err` is set.
- R8: When `host_load_n` returns high, the block finishes sending the bits it still holds. The open load enable then returns high, and `fwd_sclk` rests low.
- R9: A frame that ends before its fourth bit opens no load enable, forwards nothing and leaves `frame_err` unchanged.
- R10: `frame_err` stays set until reset. Later well-formed frames are still routed normally while it is set.
- R11: During and after reset all load enables are high, and `fwd_sclk`, `fwd_sdata`, `local_frame` and `frame_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_load_n | input | 1 | Host frame strobe, low for the length of a frame |
| host_sdata | input | 1 | Host serial data |
| host_sclk | input | 1 | Host serial clock, data taken on its rising edge |
| conv1_load_n | output | 1 | Load enable of converter 1, active low |
| conv2_load_n | output | 1 | Load enable of converter 2, active low |
| tgen_load_n | output | 1 | Load enable of the timing generator, active low |
| fwd_sdata | output | 1 | Shared serial data to the devices |
| fwd_sclk | output | 1 | Shared serial clock to the devices, idles low |
| local_frame | output | 1 | High while a frame for the local register space is in progress |
| frame_err | output | 1 | Sticky flag for a rejected frame |

## Verification
A wrong prefix count or select decode would show up at the ports within the frame that carries it. It would open the wrong load enable, open one for a rejected frame, or shift the bit stream on `fwd_sdata` by one or more positions. A bench that compares every forwarded bit and its open enable against the expected frame catches this at the first replayed bit. Faults in the queue or the drain logic would show up as lost, repeated or extra bits, or as an enable that stays low after the host strobe rises. These are visible within a few hundred nanoseconds of the frame's end. A faulty error path would show as a flag that never rises, or one that clears at the next good frame.

// File: rtl/steer_pkg.sv
package steer_pkg;

    // Frame controller states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREFIX,
        ST_ROUTE,
        ST_LOCAL,
        ST_BLOCK,
        ST_DRAIN
    } ctl_state_e;

    localparam int SEL_W       = 3;   // width of the leading select field
    localparam int PREFIX_BITS = 4;   // select field plus direction bit
    localparam int N_TARGETS   = 3;   // devices with their own load enable
    localparam int TGT_W       = 2;   // index width for N_TARGETS

    localparam logic [SEL_W-1:0] SEL_LOCAL = 3'd0;

endpackage

// File: rtl/steer_sync.sv
// steer_sync: a two-flop synchronizer for a vector of independent level signals.
// Assumes each bit is a slow level, so that bit-to-bit skew of one cycle is
// acceptable. RST_VAL sets the value seen during reset.
module steer_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    // Purpose: two register stages for the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/steer_frame_ctl.sv
// steer_frame_ctl: follows one host frame. It takes a bit on each rising edge
// of the synchronized host clock and collects the select field and the
// direction bit. It then routes the frame, flags it as local or blocks it.
// Assumes the host holds data stable around its clock rising edge and leaves
// at least a few system cycles between the strobe edges and clock edges.
module steer_frame_ctl
    import steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n_s,     // synchronized host strobe
    input  logic             sclk_s,       // synchronized host clock
    input  logic             sdata_s,      // synchronized host data
    input  logic             drain_done,   // queue empty and serializer idle
    output logic             push,         // store sdata_s in the bit queue
    output logic             flush,        // discard the bit queue
    output logic             route_active, // a target is selected
    output logic [TGT_W-1:0] target,       // 0 conv1, 1 conv2, 2 timing gen
    output logic             local_flag,
    output logic             err_set
);
    localparam int CNT_W = $clog2(PREFIX_BITS);

    ctl_state_e       state_q;
    logic             sclk_d_q;
    logic [SEL_W-1:0] prefix_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TGT_W-1:0] target_q;

    logic sclk_rise;
    logic decide;
    logic blocked;
    logic go_local;

    // Purpose: delayed host clock for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d_q <= 1'b0;
        else        sclk_d_q <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_d_q;

    // Purpose: the decision point is the fourth bit, and it carries the direction flag.
    assign decide   = (state_q == ST_PREFIX) && sclk_rise && !load_n_s &&
                      (cnt_q == CNT_W'(PREFIX_BITS - 1));
    assign blocked  = decide && (sdata_s || prefix_q[SEL_W-1]);
    assign go_local = decide && !blocked && (prefix_q == SEL_LOCAL);

    // Purpose: the frame state machine, the prefix shifter and the target register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            prefix_q <= '0;
            cnt_q    <= '0;
            target_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!load_n_s) begin
                        state_q  <= ST_PREFIX;
                        prefix_q <= '0;
                        cnt_q    <= '0;
                    end
                end
                ST_PREFIX: begin
                    if (load_n_s) begin
                        state_q <= ST_IDLE;
                    end else if (decide) begin
                        if (blocked)       state_q <= ST_BLOCK;
                        else if (go_local) state_q <= ST_LOCAL;
                        else begin
                            state_q  <= ST_ROUTE;
                            target_q <= prefix_q[TGT_W-1:0] - TGT_W'(1);
                        end
                    end else if (sclk_rise) begin
                        prefix_q <= {prefix_q[SEL_W-2:0], sdata_s};
                        cnt_q    <= cnt_q + CNT_W'(1);
                    end
                end
                ST_ROUTE: begin
                    if (load_n_s) state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (drain_done) state_q <= ST_IDLE;
                end
                ST_LOCAL, ST_BLOCK: begin
                    if (load_n_s) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: queue control. Bits are held from the first one, and dropped on abort or rejection.
    assign push  = sclk_rise && !load_n_s &&
                   ((state_q == ST_PREFIX) || (state_q == ST_ROUTE));
    assign flush = ((state_q == ST_IDLE) && !load_n_s) ||
                   ((state_q == ST_PREFIX) && load_n_s) ||
                   blocked || go_local;

    assign route_active = (state_q == ST_ROUTE) || (state_q == ST_DRAIN);
    assign target       = target_q;
    assign local_flag   = (state_q == ST_LOCAL);
    assign err_set      = blocked;
endmodule

// File: rtl/steer_bitq.sv
// steer_bitq: a single-bit-wide queue that holds host bits until the
// serializer can replay them. Flush takes priority over push and pop.
// Assumes DEPTH is a power of two. A push while the queue is full is dropped.
module steer_bitq #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic push,
    input  logic push_bit,
    input  logic pop,
    output logic head_bit,
    output logic empty,
    output logic full
);
    localparam int AW = $clog2(DEPTH);

    logic [DEPTH-1:0] mem_q;
    logic [AW-1:0]    wr_q;
    logic [AW-1:0]    rd_q;
    logic [AW:0]      cnt_q;

    logic do_push;
    logic do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // Purpose: pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + AW'(1);
            if (do_pop)  rd_q <= rd_q + AW'(1);
            cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    // Purpose: bit storage, written at the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else if (do_push && !flush) mem_q[wr_q] <= push_bit;
    end

    assign head_bit = mem_q[rd_q];
endmodule

// File: rtl/steer_serializer.sv
// steer_serializer: replays queued bits on the shared device lines. Each bit
// is placed on the data line with the clock low for HALF_CYCLES cycles. The
// clock is then high for HALF_CYCLES cycles. Assumes en stays high for as
// long as a target is selected.
module steer_serializer #(
    parameter int HALF_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic have_bit,
    input  logic bit_in,
    output logic pop,
    output logic sdata,
    output logic sclk,
    output logic busy
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

    logic          busy_q;
    logic          sclk_q;
    logic          sdata_q;
    logic [CW-1:0] cnt_q;
    logic          phase_end;

    assign pop       = en && have_bit && !busy_q;
    assign phase_end = (cnt_q == CW'(HALF_CYCLES - 1));

    // Purpose: sequences the low and high phases of one forwarded bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            sclk_q  <= 1'b0;
            sdata_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!busy_q) begin
            if (pop) begin
                busy_q  <= 1'b1;
                sclk_q  <= 1'b0;
                sdata_q <= bit_in;
                cnt_q   <= '0;
            end
        end else if (phase_end) begin
            cnt_q <= '0;
            if (!sclk_q) sclk_q <= 1'b1;
            else begin
                sclk_q <= 1'b0;
                busy_q <= 1'b0;
            end
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign sdata = sdata_q;
    assign sclk  = sclk_q;
    assign busy  = busy_q;
endmodule

// File: rtl/serial_steer_top.sv
// serial_steer_top: steers 3-wire host frames to one of three serial devices.
// It synchronizes the host lines, decodes the select prefix and queues the
// bits. It replays the bits on the shared lines while exactly one registered
// load enable is low. Assumes the replay rate (2*HALF_CYCLES+1 cycles per
// bit) is faster than the host bit rate, and that frames are spaced enough
// to let the queue drain.
module serial_steer_top
    import steer_pkg::*;
#(
    parameter int QUEUE_DEPTH = 8,
    parameter int HALF_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_load_n,
    input  logic host_sdata,
    input  logic host_sclk,
    output logic conv1_load_n,
    output logic conv2_load_n,
    output logic tgen_load_n,
    output logic fwd_sdata,
    output logic fwd_sclk,
    output logic local_frame,
    output logic frame_err
);
    logic             load_n_s, sclk_s, sdata_s;
    logic             push, flush, pop;
    logic             route_active, local_flag, err_set;
    logic [TGT_W-1:0] target;
    logic             head_bit, q_empty, q_full;
    logic             ser_busy;
    logic             err_q;
    logic [N_TARGETS-1:0] loads_q;

    steer_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_load_n, host_sclk, host_sdata}),
        .q     ({load_n_s, sclk_s, sdata_s})
    );

    steer_frame_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_n_s     (load_n_s),
        .sclk_s       (sclk_s),
        .sdata_s      (sdata_s),
        .drain_done   (q_empty && !ser_busy),
        .push         (push),
        .flush        (flush),
        .route_active (route_active),
        .target       (target),
        .local_flag   (local_flag),
        .err_set      (err_set)
    );

    steer_bitq #(.DEPTH(QUEUE_DEPTH)) u_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (push),
        .push_bit (sdata_s),
        .pop      (pop),
        .head_bit (head_bit),
        .empty    (q_empty),
        .full     (q_full)
    );

    steer_serializer #(.HALF_CYCLES(HALF_CYCLES)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (route_active && !q_full),
        .have_bit (!q_empty),
        .bit_in   (head_bit),
        .pop      (pop),
        .sdata    (fwd_sdata),
        .sclk     (fwd_sclk),
        .busy     (ser_busy)
    );

    // Purpose: one registered, active-low enable per target, low only while that target is routed.
    for (genvar gi = 0; gi < N_TARGETS; gi++) begin : g_load
        always_ff @(posedge clk) begin
            if (!rst_n) loads_q[gi] <= 1'b1;
            else        loads_q[gi] <= !(route_active && (target == TGT_W'(gi)));
        end
    end

    // Purpose: sticky error flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | err_set;
    end

    assign conv1_load_n = loads_q[0];
    assign conv2_load_n = loads_q[1];
    assign tgen_load_n  = loads_q[2];
    assign local_frame  = local_flag;
    assign frame_err    = err_q;
endmodule

// File: rtl/steer_checker.sv
// steer_checker: port-level properties of serial_steer_top, attached by bind.
module steer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] load_n,
    input logic       fwd_sclk,
    input logic       fwd_sdata,
    input logic       local_frame,
    input logic       frame_err
);
    // At most one device enabled at a time.
    p_one_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~load_n) <= 1);

    // Enables do not move during a high clock phase.
    p_load_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_sclk |-> $stable(load_n));

    // A forwarded clock pulse always has an open enable.
    p_clk_has_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fwd_sclk) |-> (load_n != 3'b111));

    // Data is held steady while the forwarded clock is high.
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_sclk |-> $stable(fwd_sdata));

    // Local frames touch no device.
    p_local_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        local_frame |-> (load_n == 3'b111 && !fwd_sclk));

    // Clock rests low when no device is enabled.
    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n == 3'b111) |-> !fwd_sclk);

    // Error flag is sticky.
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);
endmodule

bind serial_steer_top steer_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_n      ({tgen_load_n, conv2_load_n, conv1_load_n}),
    .fwd_sclk    (fwd_sclk),
    .fwd_sdata   (fwd_sdata),
    .local_frame (local_frame),
    .frame_err   (frame_err)
);

// File: tb/serial_steer_top_tb.sv
module serial_steer_top_tb;
    localparam int HP = 40;   // host clock half period, ns

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_load_n = 1'b1;
    logic host_sdata = 1'b0;
    logic host_sclk = 1'b0;
    logic conv1_load_n, conv2_load_n, tgen_load_n;
    logic fwd_sdata, fwd_sclk, local_frame, frame_err;

    int checks = 0;
    int errors = 0;
    logic exp_err = 1'b0;
    bit   done = 1'b0;

    // Scoreboard: expected forwarded bits and the target each belongs to.
    bit exp_bit_q[$];
    int exp_tgt_q[$];

    always #2 clk = ~clk;   // 250 MHz

    serial_steer_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_load_n(host_load_n), .host_sdata(host_sdata), .host_sclk(host_sclk),
        .conv1_load_n(conv1_load_n), .conv2_load_n(conv2_load_n), .tgen_load_n(tgen_load_n),
        .fwd_sdata(fwd_sdata), .fwd_sclk(fwd_sclk),
        .local_frame(local_frame), .frame_err(frame_err)
    );

    function automatic int open_tgt();
        case ({tgen_load_n, conv2_load_n, conv1_load_n})
            3'b110:  return 1;
            3'b101:  return 2;
            3'b011:  return 3;
            3'b111:  return 0;
            default: return 9;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pop one expected item per forwarded clock rising edge and compare.
    always @(posedge fwd_sclk) begin
        #1;
        checks++;
        if (exp_bit_q.size() == 0) begin
            errors++;
            $display("FAIL R4 unexpected forwarded bit: actual %0b on target %0d expected none",
                     fwd_sdata, open_tgt());
        end else begin
            automatic bit eb = exp_bit_q.pop_front();
            automatic int et = exp_tgt_q.pop_front();
            if (fwd_sdata !== eb || open_tgt() != et) begin
                errors++;
                $display("FAIL R3 forwarded bit: actual %0b/target %0d expected %0b/target %0d",
                         fwd_sdata, open_tgt(), eb, et);
            end
        end
    end

    // Driver: build a frame, queue the expected items, drive it, check the ends.
    task automatic send_frame(input string tag, input logic [2:0] sel, input logic rw,
                              input int abits, input logic [15:0] addr, input bit has_test,
                              input int dbits, input logic [31:0] data, input int cut,
                              input int exp_tgt, input bit exp_local);
        bit fb[$];
        fb.push_back(sel[2]); fb.push_back(sel[1]); fb.push_back(sel[0]);   // R2 MSB first
        fb.push_back(rw);
        for (int i = 0; i < abits; i++) fb.push_back(addr[i]);
        if (has_test) fb.push_back(1'b0);
        for (int i = 0; i < dbits; i++) fb.push_back(data[i]);
        if (cut > 0) while (fb.size() > cut) void'(fb.pop_back());
        if (exp_tgt != 0)
            foreach (fb[i]) begin
                exp_bit_q.push_back(fb[i]);
                exp_tgt_q.push_back(exp_tgt);
            end
        host_load_n = 1'b0;
        #100;
        foreach (fb[i]) begin
            host_sdata = fb[i];
            #HP host_sclk = 1'b1;
            #HP host_sclk = 1'b0;
        end
        #100;
        chk(tag, open_tgt(), exp_tgt, "open load enable during frame");
        chk(tag, int'(local_frame), int'(exp_local), "local flag during frame");
        host_load_n = 1'b1;
        #400;
        chk("R8", open_tgt(), 0, "enables after frame end");
        chk("R8", int'(fwd_sclk), 0, "forward clock after frame end");
        chk("R3", exp_bit_q.size(), 0, "bits still expected after frame");
        chk("R10", int'(frame_err), int'(exp_err), "error flag after frame");
        chk("R5", int'(local_frame), 0, "local flag after frame");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #20;
        // R11: reset state.
        chk("R11", open_tgt(), 0, "enables in reset");
        chk("R11", int'(fwd_sclk) + int'(fwd_sdata) + int'(local_frame) + int'(frame_err), 0,
            "outputs in reset");
        rst_n = 1'b1;
        #40;
        chk("R11", open_tgt(), 0, "enables after reset");

        // R1: converter 1, address 3 bits, test bit, 8 data bits.
        send_frame("R1", 3'b001, 1'b0, 3, 16'h5, 1'b1, 8, 32'hA5, 0, 1, 1'b0);
        // R1: converter 2, 10 data bits.
        send_frame("R1", 3'b010, 1'b0, 3, 16'h2, 1'b1, 10, 32'h23C, 0, 2, 1'b0);
        // R1, R2: timing generator, address 4 bits, 13 data bits.
        send_frame("R2", 3'b011, 1'b0, 4, 16'hB, 1'b0, 13, 32'h1ABC, 0, 3, 1'b0);
        // R5: local register space.
        send_frame("R5", 3'b000, 1'b0, 4, 16'h6, 1'b0, 6, 32'h2D, 0, 0, 1'b1);
        // R9: frame aborted after two bits.
        send_frame("R9", 3'b001, 1'b0, 3, 16'h0, 1'b1, 8, 32'hFF, 2, 0, 1'b0);
        // R4: aborted after three bits, before the direction bit.
        send_frame("R4", 3'b011, 1'b0, 4, 16'h0, 1'b0, 8, 32'hFF, 3, 0, 1'b0);
        // R6: unused select code 3'b101.
        exp_err = 1'b1;
        send_frame("R6", 3'b101, 1'b0, 3, 16'h1, 1'b1, 8, 32'h55, 0, 0, 1'b0);
        // R7: read request to converter 2.
        send_frame("R7", 3'b010, 1'b1, 3, 16'h1, 1'b1, 8, 32'h0F, 0, 0, 1'b0);
        // R6: unused code 3'b111.
        send_frame("R6", 3'b111, 1'b0, 3, 16'h7, 1'b1, 8, 32'hC3, 0, 0, 1'b0);
        // R10: routing continues with the error flag set.
        send_frame("R10", 3'b011, 1'b0, 4, 16'h4, 1'b0, 9, 32'h0A9, 0, 3, 1'b0);
        send_frame("R1", 3'b001, 1'b0, 3, 16'h3, 1'b1, 4, 32'h9, 0, 1, 1'b0);

        // R10: reset clears the error flag.
        rst_n = 1'b0;
        #20;
        rst_n = 1'b1;
        exp_err = 1'b0;
        #20;
        chk("R10", int'(frame_err), 0, "error flag after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule